// File: doc/BRIEF.md
# Big-Endian Word Load/Store Unit

This block connects a processor's load and store path to a data store that is byte addressed but built from 32-bit words. For every access it adds a sign-extended 16-bit displacement to a 32-bit base value to form the byte address. It then reads or writes one whole word, placing the most significant byte of the word at the lowest byte address. An access whose address is not a multiple of four is refused and reported on a one-cycle error flag.

The storage is held inside the unit as four byte-lane banks. A combinational byte-view port returns the byte at any byte address, so lane placement can be seen directly from outside. Stores commit on the sampling clock edge. Loads present their word one cycle after the strobe.

Top module: `be_lsu`

## Requirements
- R1: After reset, `ld_data` is 0, `misalign` is 0, and every byte read through `dbg_addr`/`dbg_byte` is 0x00.
- R2: The byte address is `base_val` plus `offset` sign-extended to 32 bits, wrapping modulo 2^32. Only the low log2(4*MEM_WORDS) bits select a location, so addresses that differ only above those bits reach the same word.
- R3: A store with an aligned address writes all four bytes on the clock edge where `st_en` is sampled. The new bytes appear on `dbg_byte` right after that edge.
- R4: Byte order is big-endian. Byte address 4k+j holds bits [31-8j:24-8j] of word k, for j = 0..3. For example, 0x2FE34567 stored at 0x20 gives 0x2F at 0x20 and 0x67 at 0x23.
- R5: A load with an aligned address drives the addressed word on `ld_data` from the edge that samples `ld_en` onwards.
- R6: `ld_data` keeps its value in every cycle that does not carry an aligned load. This covers stores, idle cycles and misaligned loads.
- R7: An access (`ld_en` or `st_en` high) whose address bits [1:0] are nonzero sets `misalign` to 1 for the following cycle and writes no byte.
- R8: When `ld_en` and `st_en` are both high at one aligned address, the load returns the contents from before the store, and the store still takes effect.
- R9: A cycle with neither strobe high, or with only aligned accesses, is followed by a cycle with `misalign` at 0. An idle cycle changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load word strobe |
| st_en | input | 1 | Store word strobe |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Two's-complement displacement |
| st_data | input | 32 | Word to store |
| dbg_addr | input | 32 | Byte address for the byte view |
| ld_data | output | 32 | Loaded word, registered |
| misalign | output | 1 | One-cycle misaligned-access flag |
| dbg_byte | output | 8 | Byte at `dbg_addr`, combinational |

## Verification
A lane bank that is written at the wrong index, or in the wrong lane, shows up on the byte view in the same cycle, because that port reads the banks without a register. A load of the affected word exposes the same fault on `ld_data` one edge later. A stale or sticky error state shows on `misalign` in the cycle right after the access that set it: the bench follows every misaligned access with an aligned or idle cycle and expects the flag to clear. Suppressed writes are checked by reading, through both the byte view and an aligned load, the word that a misaligned store would have corrupted.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

    localparam int WORD_BITS  = 32;
    localparam int BYTE_BITS  = 8;
    localparam int LANES      = WORD_BITS / BYTE_BITS;
    localparam int LANE_BITS  = $clog2(LANES);
    localparam int DISP_BITS  = 16;

    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [BYTE_BITS-1:0] byte_t;
    typedef logic [DISP_BITS-1:0] disp_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_kind_e;

    // Big-endian lane: lane 0 (lowest address) holds the top byte.
    function automatic byte_t lane_of(input word_t w, input int lane);
        return w[WORD_BITS-1-BYTE_BITS*lane -: BYTE_BITS];
    endfunction

    function automatic word_t sext_disp(input disp_t d);
        return {{(WORD_BITS-DISP_BITS){d[DISP_BITS-1]}}, d};
    endfunction

endpackage

// File: rtl/be_lsu_agen.sv
module be_lsu_agen
    import be_lsu_pkg::*;
#(
    parameter int ADDR_BITS = 8
) (
    input  word_t                 base_val,
    input  disp_t                 offset,
    input  logic                  ld_en,
    input  logic                  st_en,
    output logic [ADDR_BITS-1:0]  byte_addr,
    output logic                  aligned,
    output acc_kind_e             kind
);

    word_t eff_full;
    logic [WORD_BITS-ADDR_BITS-1:0] unused_ea_hi;

    always_comb begin
        eff_full     = base_val + sext_disp(offset);
        byte_addr    = eff_full[ADDR_BITS-1:0];
        unused_ea_hi = eff_full[WORD_BITS-1:ADDR_BITS];
        aligned      = (eff_full[LANE_BITS-1:0] == '0);
        kind         = acc_kind_e'({st_en, ld_en});
    end

endmodule

// File: rtl/be_lsu_lanes.sv
module be_lsu_lanes
    import be_lsu_pkg::*;
(
    input  word_t  word_in,
    input  byte_t  lanes_in  [LANES],
    output byte_t  lanes_out [LANES],
    output word_t  word_out
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        always_comb begin
            lanes_out[j] = lane_of(word_in, j);
            word_out[WORD_BITS-1-BYTE_BITS*j -: BYTE_BITS] = lanes_in[j];
        end
    end

endmodule

// File: rtl/be_lsu_wordmem.sv
module be_lsu_wordmem
    import be_lsu_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int IDX_BITS = $clog2(MEM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_BITS-1:0]  wr_idx,
    input  word_t                wr_word,
    input  logic [IDX_BITS-1:0]  rd_idx,
    output word_t                rd_word,
    input  logic [IDX_BITS-1:0]  dbg_idx,
    input  logic [LANE_BITS-1:0] dbg_lane,
    output byte_t                dbg_byte
);

    byte_t wr_lanes [LANES];
    byte_t rd_lanes [LANES];
    byte_t dbg_lanes [LANES];

    be_lsu_lanes u_lanes (
        .word_in   (wr_word),
        .lanes_in  (rd_lanes),
        .lanes_out (wr_lanes),
        .word_out  (rd_word)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_bank
        byte_t bank_q [MEM_WORDS];
        byte_t bank_d [MEM_WORDS];

        always_comb begin
            bank_d = bank_q;
            if (wr_en) begin
                bank_d[wr_idx] = wr_lanes[j];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < MEM_WORDS; k++) begin
                    bank_q[k] <= '0;
                end
            end else begin
                bank_q <= bank_d;
            end
        end

        always_comb begin
            rd_lanes[j]  = bank_q[rd_idx];
            dbg_lanes[j] = bank_q[dbg_idx];
        end
    end

    always_comb begin
        dbg_byte = dbg_lanes[dbg_lane];
    end

endmodule

// File: rtl/be_lsu.sv
module be_lsu
    import be_lsu_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_en,
    input  logic        st_en,
    input  logic [31:0] base_val,
    input  logic [15:0] offset,
    input  logic [31:0] st_data,
    input  logic [31:0] dbg_addr,
    output logic [31:0] ld_data,
    output logic        misalign,
    output logic [7:0]  dbg_byte
);

    localparam int IDX_BITS  = $clog2(MEM_WORDS);
    localparam int ADDR_BITS = IDX_BITS + LANE_BITS;

    typedef struct packed {
        word_t ld_data;
        logic  misalign;
    } lsu_state_t;

    lsu_state_t s_d, s_q;

    logic [ADDR_BITS-1:0]  acc_addr;
    logic                  acc_aligned;
    acc_kind_e             acc_kind;
    logic                  wr_en_d;
    word_t                 rd_word;
    logic [IDX_BITS-1:0]   acc_idx;
    logic [IDX_BITS-1:0]   view_idx;
    logic [LANE_BITS-1:0]  view_lane;
    logic [WORD_BITS-ADDR_BITS-1:0] unused_dbg_hi;
    logic [LANE_BITS-1:0]  unused_acc_lane;

    be_lsu_agen #(.ADDR_BITS(ADDR_BITS)) u_agen (
        .base_val  (base_val),
        .offset    (offset),
        .ld_en     (ld_en),
        .st_en     (st_en),
        .byte_addr (acc_addr),
        .aligned   (acc_aligned),
        .kind      (acc_kind)
    );

    always_comb begin
        acc_idx         = acc_addr[ADDR_BITS-1:LANE_BITS];
        unused_acc_lane = acc_addr[LANE_BITS-1:0];
        view_idx        = dbg_addr[ADDR_BITS-1:LANE_BITS];
        view_lane       = dbg_addr[LANE_BITS-1:0];
        unused_dbg_hi   = dbg_addr[WORD_BITS-1:ADDR_BITS];
    end

    be_lsu_wordmem #(.MEM_WORDS(MEM_WORDS)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_d),
        .wr_idx   (acc_idx),
        .wr_word  (st_data),
        .rd_idx   (acc_idx),
        .rd_word  (rd_word),
        .dbg_idx  (view_idx),
        .dbg_lane (view_lane),
        .dbg_byte (dbg_byte)
    );

    always_comb begin
        s_d          = s_q;
        wr_en_d      = 1'b0;
        s_d.misalign = 1'b0;
        unique case (acc_kind)
            ACC_IDLE: ;
            ACC_LOAD: begin
                if (acc_aligned) s_d.ld_data = rd_word;
                else             s_d.misalign = 1'b1;
            end
            ACC_STORE: begin
                if (acc_aligned) wr_en_d = 1'b1;
                else             s_d.misalign = 1'b1;
            end
            ACC_BOTH: begin
                // read sees the word before this edge's write
                if (acc_aligned) begin
                    s_d.ld_data = rd_word;
                    wr_en_d     = 1'b1;
                end else begin
                    s_d.misalign = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ld_data  = s_q.ld_data;
    assign misalign = s_q.misalign;

endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_en,
    input logic        st_en,
    input logic [31:0] base_val,
    input logic [15:0] offset,
    input logic [31:0] ld_data,
    input logic        misalign
);

    logic [31:0] ea;
    logic        any_acc;
    logic        odd;

    always_comb begin
        ea      = base_val + {{16{offset[15]}}, offset};
        any_acc = ld_en || st_en;
        odd     = (ea[1:0] != 2'b00);
    end

    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (any_acc && odd) |=> misalign);

    a_r9_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !any_acc |=> !misalign);

    a_r9_flag_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (any_acc && !odd) |=> !misalign);

    a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && !odd) |=> $stable(ld_data));

    a_r7_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && odd) |=> $stable(ld_data));

endmodule

bind be_lsu be_lsu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .st_en    (st_en),
    .base_val (base_val),
    .offset   (offset),
    .ld_data  (ld_data),
    .misalign (misalign)
);

// File: tb/sim_be_lsu.sv
module sim_be_lsu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic        st_en = 1'b0;
    logic [31:0] base_val = '0;
    logic [15:0] offset = '0;
    logic [31:0] st_data = '0;
    logic [31:0] dbg_addr = '0;
    logic [31:0] ld_data;
    logic        misalign;
    logic [7:0]  dbg_byte;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    be_lsu u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .st_en(st_en),
        .base_val(base_val), .offset(offset), .st_data(st_data),
        .dbg_addr(dbg_addr), .ld_data(ld_data), .misalign(misalign),
        .dbg_byte(dbg_byte)
    );

    // {store, base, offset, data, exp_misalign, exp_ld_data}
    localparam int NV = 12;
    localparam logic [113:0] VEC [NV] = '{
        {1'b1, 32'h0000_0100, 16'h0020, 32'h2FE3_4567, 1'b0, 32'h0000_0000},
        {1'b1, 32'h0000_0040, 16'hFFFC, 32'h1234_4321, 1'b0, 32'h0000_0000},
        {1'b1, 32'h0000_0010, 16'h0002, 32'hDEAD_BEEF, 1'b1, 32'h0000_0000},
        {1'b0, 32'h0000_0000, 16'h0020, 32'h0,         1'b0, 32'h2FE3_4567},
        {1'b0, 32'h0000_0050, 16'hFFEC, 32'h0,         1'b0, 32'h1234_4321},
        {1'b0, 32'h0000_0010, 16'h0002, 32'h0,         1'b1, 32'h1234_4321},
        {1'b0, 32'h0000_0010, 16'h0000, 32'h0,         1'b0, 32'h0000_0000},
        {1'b0, 32'hFFFF_FF00, 16'h0120, 32'h0,         1'b0, 32'h2FE3_4567},
        {1'b0, 32'h0000_1000, 16'h0020, 32'h0,         1'b0, 32'h2FE3_4567},
        {1'b1, 32'h0000_0000, 16'h00FC, 32'hA1B2_C3D4, 1'b0, 32'h2FE3_4567},
        {1'b0, 32'h0000_00FC, 16'h0000, 32'h0,         1'b0, 32'hA1B2_C3D4},
        {1'b0, 32'h0000_0003, 16'h0000, 32'h0,         1'b1, 32'hA1B2_C3D4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic ld, input logic st, input logic [31:0] b,
                          input logic [15:0] o, input logic [31:0] d);
        @(negedge clk);
        ld_en = ld; st_en = st; base_val = b; offset = o; st_data = d;
        @(negedge clk);
        ld_en = 1'b0; st_en = 1'b0;
    endtask

    task automatic view(input string req, input logic [31:0] a, input logic [7:0] exp);
        dbg_addr = a;
        #1;
        chk(req, {24'h0, dbg_byte}, {24'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ld_data", ld_data, 32'h0);
        chk("R1 misalign", {31'h0, misalign}, 32'h0);
        view("R1 byte", 32'h00, 8'h00);
        view("R1 byte", 32'h20, 8'h00);
        view("R1 byte", 32'hFF, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [113:0] v;
            string tag;
            v = VEC[i];
            access(~v[113], v[113], v[112:81], v[80:65], v[64:33]);
            if (v[32])                        tag = "R7";
            else if (i == 4 || i == 7 || i == 8) tag = "R2";
            else if (v[113])                  tag = "R3";
            else                              tag = "R5";
            chk({tag, " misalign"}, {31'h0, misalign}, {31'h0, v[32]});
            chk({tag, "/R6 ld_data"}, ld_data, v[31:0]);
        end

        // R4: big-endian lane placement
        view("R4 0x20", 32'h20, 8'h2F);
        view("R4 0x21", 32'h21, 8'hE3);
        view("R4 0x22", 32'h22, 8'h45);
        view("R4 0x23", 32'h23, 8'h67);
        view("R4 0x3C", 32'h3C, 8'h12);
        view("R4 0x3F", 32'h3F, 8'h21);
        view("R4 0xFC", 32'hFC, 8'hA1);
        // R7: misaligned store wrote nothing
        view("R7 0x10", 32'h10, 8'h00);
        view("R7 0x12", 32'h12, 8'h00);
        view("R7 0x13", 32'h13, 8'h00);

        // R8: load and store together return old data
        dbg_addr = 32'h20;
        access(1'b1, 1'b1, 32'h20, 16'h0, 32'h5566_7788);
        chk("R8 old data", ld_data, 32'h2FE3_4567);
        view("R3 new byte", 32'h20, 8'h55);
        view("R3 new byte", 32'h23, 8'h88);
        access(1'b1, 1'b0, 32'h20, 16'h0, 32'h0);
        chk("R8 new data", ld_data, 32'h5566_7788);

        // R7 then R9: flag lasts one cycle
        access(1'b1, 1'b0, 32'h1, 16'h0, 32'h0);
        chk("R7 misalign", {31'h0, misalign}, 32'h1);
        @(negedge clk);
        chk("R9 misalign clear", {31'h0, misalign}, 32'h0);
        chk("R9 ld_data", ld_data, 32'h5566_7788);
        view("R9 byte", 32'h21, 8'h66);

        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule